// File: doc/BRIEF.md
# Phase build-out controller

This block sits in front of the phase detector of a digital clock loop. It removes the phase step that the loop would otherwise see when the selected reference input changes. When a reference switch is flagged while the block is enabled, the block measures how far the loop feedback lags the new reference. It measures this in counts of a fast sampling clock and keeps the result as a stored offset. From then on, every rising edge of the reference produces a virtual reference pulse that is delayed by the stored offset. The loop therefore keeps tracking the phase it already had.

The block is enabled when either of two levels is high: an external enable or an automatic enable from the mode controller. While disabled, a switch stores nothing. The stored offset instead drains toward zero by a bounded step once per slew tick, so the loop realigns to the input at a limited rate. An active-low clear input resets the stored offset to zero. The clear takes effect only when the input stays low long enough; shorter glitches are ignored. The phase detector, the loop filter and the oscillator lie outside this block.

Top module: `pbo_tie_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, `offset_o` reads 0 and `vref_o` is low.
- R2: After a `ref_switch` pulse while enabled, the block waits for the next reference rising edge and then the next feedback rising edge. It stores in `offset_o` the number of fast-clock cycles from that reference edge to that feedback edge. Edges that arrive in the same cycle store 0.
- R3: The block counts as enabled when `en_pin` or `en_auto` is high; `en_auto` alone is enough for R2 capture.
- R4: While enabled, `offset_o` changes only through an R2 capture or an R6 clear. Feedback edges without a preceding switch leave it unchanged.
- R5: Each reference rising edge produces exactly one single-cycle `vref_o` pulse. The pulse comes `offset_o` fast-clock cycles after the pulse that a zero offset would give, and a zero offset gives the pulse on the cycle after the edge is sampled.
- R6: `clr_n` held low for at least CLR_MIN_NS (after a two-stage synchronizer) forces `offset_o` to 0. A low pulse clearly shorter than that leaves `offset_o` unchanged.
- R7: While disabled, `offset_o` decreases by exactly SLEW_STEP counts once per slew tick, one tick every TICK_NS. It stops at 0 and never rises.
- R8: A `ref_switch` pulse while disabled leaves `offset_o` unchanged by any later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Currently selected reference (level, synchronous to clk) |
| fb_in | input | 1 | Loop feedback clock (level, synchronous to clk) |
| ref_switch | input | 1 | One-cycle pulse flagging that the reference was switched |
| en_pin | input | 1 | External enable level |
| en_auto | input | 1 | Automatic enable level from the mode controller |
| clr_n | input | 1 | Active-low, width-qualified offset clear (asynchronous) |
| vref_o | output | 1 | Virtual reference pulse to the phase detector |
| offset_o | output | PH_W | Currently applied phase offset in fast-clock counts |

## Verification
A wrong stored offset appears on `offset_o` on the cycle after the update that caused it. At the next reference edge it also appears as a `vref_o` pulse whose delay from that edge differs from the offset. A stuck or mis-loaded delay counter therefore shows within one reference period. An arm flag left set, or a clear qualifier that fires too early, changes `offset_o` in a scenario where it must hold. A slew timebase that is wrong shows as uneven spacing between single-count decrements within two ticks.

// File: rtl/pbo_pkg.sv
package pbo_pkg;

    // Which update the stored offset takes in a given cycle.
    typedef enum logic [1:0] {
        OFS_HOLD,
        OFS_CLEAR,
        OFS_CAPTURE,
        OFS_SLEW
    } ofs_op_e;

    // Rising-edge events detected on the two monitored clocks.
    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_evt_t;

    function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // One bounded step toward zero, saturating at zero.
    function automatic int unsigned step_toward_zero(input int unsigned v, input int unsigned s);
        return (v > s) ? v - s : 0;
    endfunction

endpackage

// File: rtl/pbo_phase_meas.sv
module pbo_phase_meas
    import pbo_pkg::*;
#(
    parameter int PH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_in,
    input  logic            fb_in,
    output edge_evt_t       evt,
    output logic [PH_W-1:0] phase
);

    logic            ref_d;
    logic            fb_d;
    logic [PH_W-1:0] since_ref;

    assign evt.ref_rise = ref_in & ~ref_d;
    assign evt.fb_rise  = fb_in & ~fb_d;

    // Cycles elapsed since the latest reference edge; the counter restarts
    // on every edge, so the result is naturally modulo the reference period.
    assign phase = evt.ref_rise ? '0 : since_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d     <= 1'b0;
            fb_d      <= 1'b0;
            since_ref <= '0;
        end else begin
            ref_d <= ref_in;
            fb_d  <= fb_in;
            if (evt.ref_rise)
                since_ref <= PH_W'(1);
            else if (since_ref != '1)
                since_ref <= since_ref + PH_W'(1);
        end
    end

endmodule

// File: rtl/pbo_clr_qual.sv
module pbo_clr_qual #(
    parameter int HOLD_CYC = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    output logic clr_hit
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] low_cnt;
    logic             clr_s;

    assign clr_s   = sync_q[1];
    assign clr_hit = !clr_s && (low_cnt == CNT_W'(HOLD_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            low_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], clr_n};
            if (clr_s)
                low_cnt <= '0;
            else if (low_cnt != CNT_W'(HOLD_CYC))
                low_cnt <= low_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pbo_vref_gen.sv
module pbo_vref_gen #(
    parameter int PH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_rise,
    input  logic [PH_W-1:0] ofs,
    output logic            vref
);

    logic [PH_W-1:0] dly;
    logic            active;

    always_ff @(posedge clk) begin
        if (rst) begin
            vref   <= 1'b0;
            dly    <= '0;
            active <= 1'b0;
        end else begin
            vref <= 1'b0;
            if (ref_rise) begin
                if (ofs == '0) begin
                    vref   <= 1'b1;
                    active <= 1'b0;
                end else begin
                    dly    <= ofs;
                    active <= 1'b1;
                end
            end else if (active) begin
                if (dly == PH_W'(1)) begin
                    vref   <= 1'b1;
                    active <= 1'b0;
                end
                dly <= dly - PH_W'(1);
            end
        end
    end

endmodule

// File: rtl/pbo_tie_ctrl.sv
module pbo_tie_ctrl
    import pbo_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int CLR_MIN_NS    = 300,
    parameter int TICK_NS       = 125000,
    parameter int SLEW_PS       = 5000,
    parameter int PH_W          = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_in,
    input  logic            fb_in,
    input  logic            ref_switch,
    input  logic            en_pin,
    input  logic            en_auto,
    input  logic            clr_n,
    output logic            vref_o,
    output logic [PH_W-1:0] offset_o
);

    localparam int CLR_CYCLES  = int'(div_ceil(CLR_MIN_NS * 1000, CLK_PERIOD_PS));
    localparam int TICK_CYCLES = int'(div_ceil(TICK_NS * 1000, CLK_PERIOD_PS));
    localparam int SLEW_STEP   = (SLEW_PS >= CLK_PERIOD_PS) ? SLEW_PS / CLK_PERIOD_PS : 1;
    localparam int TICK_W      = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    edge_evt_t       evt;
    logic [PH_W-1:0] meas_phase;
    logic            clr_hit;
    logic            en_any;
    logic            armed;
    logic            ref_seen;
    logic            cap_fire;
    logic            tick;
    logic [TICK_W-1:0] tick_cnt;
    logic [PH_W-1:0] offset_q;
    ofs_op_e         op;

    pbo_phase_meas #(.PH_W(PH_W)) u_meas (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .evt    (evt),
        .phase  (meas_phase)
    );

    pbo_clr_qual #(.HOLD_CYC(CLR_CYCLES)) u_clr (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (clr_n),
        .clr_hit (clr_hit)
    );

    pbo_vref_gen #(.PH_W(PH_W)) u_vref (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (evt.ref_rise),
        .ofs      (offset_q),
        .vref     (vref_o)
    );

    assign en_any   = en_pin | en_auto;
    assign cap_fire = en_any && armed && evt.fb_rise && (ref_seen || evt.ref_rise);
    assign tick     = (tick_cnt == TICK_W'(TICK_CYCLES - 1));
    assign offset_o = offset_q;

    // Slew timebase: free-running, one tick every TICK_CYCLES.
    always_ff @(posedge clk) begin
        if (rst)
            tick_cnt <= '0;
        else if (tick)
            tick_cnt <= '0;
        else
            tick_cnt <= tick_cnt + TICK_W'(1);
    end

    // Arm on a switch while enabled; wait for a reference edge, then capture
    // at the following feedback edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            ref_seen <= 1'b0;
        end else if (ref_switch && en_any) begin
            armed    <= 1'b1;
            ref_seen <= 1'b0;
        end else if (!en_any) begin
            armed    <= 1'b0;
            ref_seen <= 1'b0;
        end else if (armed) begin
            if (cap_fire) begin
                armed    <= 1'b0;
                ref_seen <= 1'b0;
            end else if (evt.ref_rise) begin
                ref_seen <= 1'b1;
            end
        end
    end

    // Priority: clear, then capture, then slew while disabled.
    always_comb begin
        op = OFS_HOLD;
        if (clr_hit)
            op = OFS_CLEAR;
        else if (cap_fire)
            op = OFS_CAPTURE;
        else if (!en_any && tick)
            op = OFS_SLEW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
        end else begin
            case (op)
                OFS_CLEAR:   offset_q <= '0;
                OFS_CAPTURE: offset_q <= meas_phase;
                OFS_SLEW:    offset_q <= PH_W'(step_toward_zero(32'(offset_q), SLEW_STEP));
                default:     offset_q <= offset_q;
            endcase
        end
    end

endmodule

// File: rtl/pbo_tie_ctrl_chk.sv
module pbo_tie_ctrl_chk #(
    parameter int PH_W      = 16,
    parameter int SLEW_STEP = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            en_any,
    input logic            clr_hit,
    input logic            cap_fire,
    input logic            ref_rise,
    input logic [PH_W-1:0] meas_phase,
    input logic [PH_W-1:0] offset_o,
    input logic            vref_o
);

    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q === 1'b1)
            AST_RESET_STATE: assert (offset_o == '0 && !vref_o); // R1
    end

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && !clr_hit) |=> (offset_o == $past(meas_phase))); // R2

    AST_HOLD_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (en_any && !cap_fire && !clr_hit) |=> $stable(offset_o)); // R4

    AST_VREF_ZERO_LAT: assert property (@(posedge clk) disable iff (rst)
        (ref_rise && offset_o == '0) |=> vref_o); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> (offset_o == '0)); // R6

    AST_SLEW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (!en_any && !clr_hit) |=> ((offset_o <= $past(offset_o)) &&
            ((offset_o == $past(offset_o)) || (offset_o == '0) ||
             (offset_o == $past(offset_o) - PH_W'(SLEW_STEP))))); // R7

endmodule

bind pbo_tie_ctrl pbo_tie_ctrl_chk #(.PH_W(PH_W), .SLEW_STEP(SLEW_STEP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_any     (en_any),
    .clr_hit    (clr_hit),
    .cap_fire   (cap_fire),
    .ref_rise   (evt.ref_rise),
    .meas_phase (meas_phase),
    .offset_o   (offset_o),
    .vref_o     (vref_o)
);

// File: tb/tb_pbo_tie_ctrl.sv
`timescale 1ns/1ps
module tb_pbo_tie_ctrl;

    localparam int PH_W      = 16;
    localparam int TICK_NS   = 200;   // 40 cycles at 5 ns
    localparam int TICK_CYC  = 40;
    localparam int CLR_CYC   = 60;    // 300 ns at 5 ns

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ref_in = 1'b0;
    logic            fb_in = 1'b0;
    logic            ref_switch = 1'b0;
    logic            en_pin = 1'b0;
    logic            en_auto = 1'b0;
    logic            clr_n = 1'b1;
    logic            vref_o;
    logic [PH_W-1:0] offset_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    pbo_tie_ctrl #(.TICK_NS(TICK_NS), .PH_W(PH_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .ref_switch (ref_switch),
        .en_pin     (en_pin),
        .en_auto    (en_auto),
        .clr_n      (clr_n),
        .vref_o     (vref_o),
        .offset_o   (offset_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_switch();
        @(negedge clk); ref_switch = 1'b1;
        @(negedge clk); ref_switch = 1'b0;
    endtask

    // Reference edge, then feedback edge d cycles later.
    task automatic ref_fb(input int d);
        @(negedge clk);
        ref_in = 1'b1;
        if (d == 0) fb_in = 1'b1;
        for (int i = 0; i < d; i++) @(negedge clk);
        fb_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Reference edge without feedback; measure vref latency and pulse count.
    task automatic vref_latency(input string tag, input int exp_lat);
        int lat = -1;
        int pulses = 0;
        @(negedge clk);
        ref_in = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 2) ref_in = 1'b0;
            if (vref_o) begin
                pulses++;
                if (lat < 0) lat = k;
            end
        end
        chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        chk(pulses == 1, {tag, " pulse count"}, pulses, 1);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(offset_o == 0, "R1 offset in reset", offset_o, 0);
        chk(vref_o == 1'b0, "R1 vref in reset", vref_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(offset_o == 0, "R1 offset after reset", offset_o, 0);
    endtask

    task automatic t_capture();
        en_pin = 1'b1;
        pulse_switch(); ref_fb(9);
        chk(offset_o == 9, "R2 capture 9", offset_o, 9);
        pulse_switch(); ref_fb(23);
        chk(offset_o == 23, "R2 capture 23", offset_o, 23);
        pulse_switch(); ref_fb(0);
        chk(offset_o == 0, "R2 same-cycle edges", offset_o, 0);
        pulse_switch(); ref_fb(12);
        chk(offset_o == 12, "R2 capture 12", offset_o, 12);
    endtask

    task automatic t_hold();
        ref_fb(5);
        ref_fb(30);
        chk(offset_o == 12, "R4 hold without switch", offset_o, 12);
    endtask

    task automatic t_vref();
        vref_latency("R5 offset 12", 12);
        pulse_switch(); ref_fb(3);
        vref_latency("R5 offset 3", 3);
        pulse_switch(); ref_fb(0);
        vref_latency("R5 offset 0", 0);
    endtask

    task automatic t_auto();
        en_pin  = 1'b0;
        en_auto = 1'b1;
        pulse_switch(); ref_fb(17);
        chk(offset_o == 17, "R3 auto enable capture", offset_o, 17);
    endtask

    task automatic t_clear();
        @(negedge clk); clr_n = 1'b0;
        repeat (CLR_CYC - 10) @(negedge clk);
        clr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(offset_o == 17, "R6 short clear ignored", offset_o, 17);
        clr_n = 1'b0;
        repeat (CLR_CYC + 20) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(offset_o == 0, "R6 long clear", offset_o, 0);
    endtask

    task automatic t_slew();
        int prev;
        int steps = 0;
        int bad_step = 0;
        int last_at = -1;
        int bad_gap = 0;
        pulse_switch(); ref_fb(7);
        chk(offset_o == 7, "R7 preload 7", offset_o, 7);
        @(negedge clk);
        en_auto = 1'b0;
        en_pin  = 1'b0;
        prev = offset_o;
        for (int c = 0; c < 10 * TICK_CYC; c++) begin
            @(negedge clk);
            if (int'(offset_o) != prev) begin
                if (prev - int'(offset_o) != 1) bad_step++;
                if (last_at >= 0 && c - last_at != TICK_CYC) bad_gap++;
                last_at = c;
                steps++;
                prev = offset_o;
            end
        end
        chk(steps == 7 && bad_step == 0, "R7 single-count steps", steps, 7);
        chk(bad_gap == 0, "R7 one step per tick", bad_gap, 0);
        chk(offset_o == 0, "R7 settles at zero", offset_o, 0);
    endtask

    task automatic t_disabled_switch();
        pulse_switch(); ref_fb(9);
        ref_fb(4);
        chk(offset_o == 0, "R8 switch while disabled", offset_o, 0);
    endtask

    initial begin
        t_reset();
        t_capture();
        t_hold();
        t_vref();
        t_auto();
        t_clear();
        t_slew();
        t_disabled_switch();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule